// File: doc/BRIEF.md
# Microcontroller Bus Register Interface

This block connects a byte-wide microcontroller bus to a piece of application logic, for example a serial transmit and receive engine. It decodes each bus cycle against a fixed base address and gives the processor four registers: a control register, a status register, an input word register and an output word register. Through these registers software enables the application logic, starts it, feeds it words, collects results and services its interrupts.

The bus strobes are taken through a synchroniser before they act. A write takes effect once per strobe, on the rising edge after the synchronised strobe first asserts. Read data is driven only while a synchronised read strobe to a decoded address is active, and is zero at all other times. Cycles that fetch program code, and cycles to any other base address, are ignored.

Status flags are sticky: an event sets them, and writing zero to them clears them. An active-low interrupt line reports any pending flag event while interrupts are enabled. The application logic sees a reset line, a start level and the current input word with a one-cycle load pulse.

Top module: `uc_regif`

## Requirements
- R1: The address splits into a base field (bits 7:2, default 6'h2A) and a register select (bits 1:0: 0 control, 1 status, 2 input word, 3 output word). A write to a different base field changes nothing, and a read from it returns zero.
- R2: While busPsenN is low, no write changes any register and rdData stays zero, even at a matching address.
- R3: A write commits on the third rising edge after busWrN first goes low. The control register holds enable in bit 7, interrupt enable in bit 6 and start in bit 5. Bits 4:0 read as zero. appStart follows bit 5.
- R4: appRstN equals control bit 7, so clearing that bit holds the application logic in reset and setting it releases the logic.
- R5: The status register reads error in bit 7, need-data in bit 6, data-ready in bit 5, the live appBusy level in bit 4 and interrupt-pending in bit 3. Bits 2:0 read as zero.
- R6: A status write clears each of bits 7, 6, 5 and 3 that it writes as 0 and leaves alone those written as 1. While appError stays high, the error flag stays set.
- R7: An event in the same cycle as a clearing write leaves the flag set.
- R8: Interrupt-pending is set when interrupt enable is 1 and appError, appNeedData or appOutValid is high. intN is low exactly while interrupt-pending is set. With interrupt enable at 0 the flags still set but intN stays high.
- R9: A write to the input word register drives the value onto appWord and raises appWordWr for exactly one cycle.
- R10: A high appOutValid captures appWordOut into the output word register and sets data-ready. Register 3 reads that word, and writes to it are ignored.
- R11: rdData is zero except on the second and later cycles of a low busRdN at a decoded address, while busPsenN is high. In those cycles it carries the selected register.
- R12: After reset all registers and flags are zero, intN is high and appRstN is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 8 | Latched bus address (base field and register select) |
| busDataIn | input | 8 | Write data from the processor |
| busWrN | input | 1 | Active-low write strobe |
| busRdN | input | 1 | Active-low read strobe |
| busPsenN | input | 1 | Active-low program fetch strobe; when low the cycle is ignored |
| rdData | output | 8 | Read data, zero when not reading |
| intN | output | 1 | Active-low interrupt request |
| appRstN | output | 1 | Active-low reset to the application logic |
| appStart | output | 1 | Start level to the application logic |
| appWord | output | 8 | Current input word |
| appWordWr | output | 1 | One-cycle pulse when a new input word is written |
| appWordOut | input | 8 | Word produced by the application logic |
| appOutValid | input | 1 | appWordOut is valid; latch it |
| appNeedData | input | 1 | Application wants the next input word |
| appError | input | 1 | Error condition, level |
| appBusy | input | 1 | Application busy, shown live in status |

## Verification
The assertions check the following on every cycle:
- Read data is zero when no read strobe has been seen in the last two cycles.
- The application reset changes only after a committed control write.
- The interrupt line falls only after an application event, and rises only after a committed status write.
- The input word changes only together with its load pulse.

Other behaviour can only be shown by the bench's scenarios:
- Program-fetch and foreign-address cycles are ignored.
- Write-one leaves a flag and write-zero clears it.
- A persistent error survives a clear.
- An event in the same cycle as a clearing write wins.
- Interrupts stay masked while interrupt enable is 0.

All of these are compared cycle by cycle against a behavioural model.

// File: rtl/uc_regif_pkg.sv
package uc_regif_pkg;

  localparam int SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_CTRL = 2'd0,
    SEL_STAT = 2'd1,
    SEL_DIN  = 2'd2,
    SEL_DOUT = 2'd3
  } regSel_e;

  // control register bit positions
  localparam int CTRL_EN_BIT = 7;
  localparam int CTRL_IE_BIT = 6;
  localparam int CTRL_GO_BIT = 5;

  // status register bit positions
  localparam int ST_ERR_BIT  = 7;
  localparam int ST_NEED_BIT = 6;
  localparam int ST_RDY_BIT  = 5;
  localparam int ST_BUSY_BIT = 4;
  localparam int ST_INT_BIT  = 3;

  // number of sticky event flags (ready, need, error) starting at ST_RDY_BIT
  localparam int NUM_FLAGS = 3;

  typedef struct packed {
    logic    wrCtrl;
    logic    wrStat;
    logic    wrDin;
    logic    rdEn;
    regSel_e sel;
  } regStrobe_t;

endpackage

// File: rtl/uc_bus_ctrl.sv
module uc_bus_ctrl
  import uc_regif_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter logic [ADDR_W-SEL_W-1:0] BASE_ADDR = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrN,
  input  logic              busRdN,
  input  logic              busPsenN,
  output regStrobe_t        strb
);

  logic [SYNC_STAGES:0] wrTap;
  logic [SYNC_STAGES:0] rdTap;
  logic                 wrLast;
  logic                 wrCommit;
  logic                 rdActive;
  logic                 addrHit;
  regSel_e              selCode;

  assign wrTap[0] = ~busWrN;
  assign rdTap[0] = ~busRdN;

  // synchroniser chains for both strobes
  for (genvar i = 1; i <= SYNC_STAGES; i++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        wrTap[i] <= 1'b0;
        rdTap[i] <= 1'b0;
      end else begin
        wrTap[i] <= wrTap[i-1];
        rdTap[i] <= rdTap[i-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wrLast <= 1'b0;
    else       wrLast <= wrTap[SYNC_STAGES];
  end

  // one commit per strobe: rising edge of the synchronised write
  assign wrCommit = wrTap[SYNC_STAGES] & ~wrLast;
  assign rdActive = rdTap[SYNC_STAGES];
  assign addrHit  = busPsenN && (busAddr[ADDR_W-1:SEL_W] == BASE_ADDR);
  assign selCode  = regSel_e'(busAddr[SEL_W-1:0]);

  always_comb begin
    strb.sel    = selCode;
    strb.wrCtrl = wrCommit && addrHit && (selCode == SEL_CTRL);
    strb.wrStat = wrCommit && addrHit && (selCode == SEL_STAT);
    strb.wrDin  = wrCommit && addrHit && (selCode == SEL_DIN);
    strb.rdEn   = rdActive && addrHit;
  end

endmodule

// File: rtl/uc_reg_datapath.sv
module uc_reg_datapath
  import uc_regif_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              appError,
  input  logic              appNeedData,
  input  logic              appOutValid,
  input  logic              appBusy,
  input  logic [DATA_W-1:0] appWordOut,
  output logic [DATA_W-1:0] rdData,
  output logic              appRstN,
  output logic              appStart,
  output logic [DATA_W-1:0] appWord,
  output logic              appWordWr,
  output logic              intN
);

  logic                 ctrlEn, ctrlIe, ctrlGo;
  logic [NUM_FLAGS-1:0] flagQ;
  logic [NUM_FLAGS-1:0] flagSet;
  logic                 intPend;
  logic [DATA_W-1:0]    dinQ;
  logic [DATA_W-1:0]    doutQ;
  logic [DATA_W-1:0]    ctrlView;
  logic [DATA_W-1:0]    statView;

  // index 0 ready, 1 need, 2 error (status bits 5..7)
  assign flagSet = {appError, appNeedData, appOutValid};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlEn <= 1'b0;
      ctrlIe <= 1'b0;
      ctrlGo <= 1'b0;
    end else if (strb.wrCtrl) begin
      ctrlEn <= wrData[CTRL_EN_BIT];
      ctrlIe <= wrData[CTRL_IE_BIT];
      ctrlGo <= wrData[CTRL_GO_BIT];
    end
  end

  // sticky flags: write zero clears, a new event wins over the clear
  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) flagQ[g] <= 1'b0;
      else       flagQ[g] <= (flagQ[g] & ~(strb.wrStat & ~wrData[ST_RDY_BIT+g]))
                             | flagSet[g];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) intPend <= 1'b0;
    else       intPend <= (intPend & ~(strb.wrStat & ~wrData[ST_INT_BIT]))
                          | (ctrlIe & (|flagSet));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dinQ      <= '0;
      appWordWr <= 1'b0;
    end else begin
      appWordWr <= strb.wrDin;
      if (strb.wrDin) dinQ <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            doutQ <= '0;
    else if (appOutValid) doutQ <= appWordOut;
  end

  always_comb begin
    ctrlView              = '0;
    ctrlView[CTRL_EN_BIT] = ctrlEn;
    ctrlView[CTRL_IE_BIT] = ctrlIe;
    ctrlView[CTRL_GO_BIT] = ctrlGo;
    statView              = '0;
    statView[ST_RDY_BIT+NUM_FLAGS-1:ST_RDY_BIT] = flagQ;
    statView[ST_BUSY_BIT] = appBusy;
    statView[ST_INT_BIT]  = intPend;
  end

  always_comb begin
    rdData = '0;
    if (strb.rdEn) begin
      unique case (strb.sel)
        SEL_CTRL: rdData = ctrlView;
        SEL_STAT: rdData = statView;
        SEL_DIN:  rdData = dinQ;
        SEL_DOUT: rdData = doutQ;
      endcase
    end
  end

  assign appRstN  = ctrlEn;
  assign appStart = ctrlGo;
  assign appWord  = dinQ;
  assign intN     = ~intPend;

endmodule

// File: rtl/uc_regif.sv
module uc_regif
  import uc_regif_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter logic [ADDR_W-SEL_W-1:0] BASE_ADDR = 6'h2A
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busDataIn,
  input  logic              busWrN,
  input  logic              busRdN,
  input  logic              busPsenN,
  output logic [DATA_W-1:0] rdData,
  output logic              intN,
  output logic              appRstN,
  output logic              appStart,
  output logic [DATA_W-1:0] appWord,
  output logic              appWordWr,
  input  logic [DATA_W-1:0] appWordOut,
  input  logic              appOutValid,
  input  logic              appNeedData,
  input  logic              appError,
  input  logic              appBusy
);

  regStrobe_t strb;

  uc_bus_ctrl #(
    .ADDR_W      (ADDR_W),
    .SYNC_STAGES (SYNC_STAGES),
    .BASE_ADDR   (BASE_ADDR)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busAddr  (busAddr),
    .busWrN   (busWrN),
    .busRdN   (busRdN),
    .busPsenN (busPsenN),
    .strb     (strb)
  );

  uc_reg_datapath #(
    .DATA_W (DATA_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .wrData      (busDataIn),
    .appError    (appError),
    .appNeedData (appNeedData),
    .appOutValid (appOutValid),
    .appBusy     (appBusy),
    .appWordOut  (appWordOut),
    .rdData      (rdData),
    .appRstN     (appRstN),
    .appStart    (appStart),
    .appWord     (appWord),
    .appWordWr   (appWordWr),
    .intN        (intN)
  );

endmodule

// File: rtl/uc_regif_checker.sv
module uc_regif_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              busRdN,
  input logic [DATA_W-1:0] rdData,
  input logic              intN,
  input logic              appError,
  input logic              appNeedData,
  input logic              appOutValid,
  input logic              ctrlWrite,
  input logic              statWrite,
  input logic              appRstN,
  input logic [DATA_W-1:0] appWord,
  input logic              appWordWr
);

  logic [1:0] upCycles;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                upCycles <= '0;
    else if (upCycles != 2'd3) upCycles <= upCycles + 2'd1;
  end

  assert_idle_bus_zero_R11: assert property (@(posedge clk) disable iff (!rstN)
    (upCycles >= 2'd2 && $past(busRdN) && $past(busRdN, 2)) |-> (rdData == '0));

  assert_reset_needs_ctrl_write_R4: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(appRstN) |-> $past(ctrlWrite));

  assert_irq_needs_event_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(intN) |-> $past(appError || appNeedData || appOutValid));

  assert_irq_release_by_write_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intN) |-> $past(statWrite));

  assert_word_with_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(appWord) |-> appWordWr);

endmodule

bind uc_regif uc_regif_checker #(.DATA_W(DATA_W)) u_regifChk (
  .clk         (clk),
  .rstN        (rstN),
  .busRdN      (busRdN),
  .rdData      (rdData),
  .intN        (intN),
  .appError    (appError),
  .appNeedData (appNeedData),
  .appOutValid (appOutValid),
  .ctrlWrite   (strb.wrCtrl),
  .statWrite   (strb.wrStat),
  .appRstN     (appRstN),
  .appWord     (appWord),
  .appWordWr   (appWordWr)
);

// File: tb/uc_regif_bench.sv
`timescale 1ns/1ps
module uc_regif_bench;

  localparam logic [5:0] BASE = 6'h2A;
  localparam logic [5:0] OTHER = 6'h15;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] busAddr = 8'h00;
  logic [7:0] busDataIn = 8'h00;
  logic       busWrN = 1'b1, busRdN = 1'b1, busPsenN = 1'b1;
  logic [7:0] rdData;
  logic       intN, appRstN, appStart, appWordWr;
  logic [7:0] appWord;
  logic [7:0] appWordOut = 8'h00;
  logic       appOutValid = 1'b0, appNeedData = 1'b0, appError = 1'b0, appBusy = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  uc_regif u_uc_regif (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busDataIn(busDataIn),
    .busWrN(busWrN), .busRdN(busRdN), .busPsenN(busPsenN), .rdData(rdData),
    .intN(intN), .appRstN(appRstN), .appStart(appStart), .appWord(appWord),
    .appWordWr(appWordWr), .appWordOut(appWordOut), .appOutValid(appOutValid),
    .appNeedData(appNeedData), .appError(appError), .appBusy(appBusy)
  );

  // ---------------- behavioural reference model ----------------
  logic [2:0] mCtrl;             // {enable, irq enable, start}
  logic       mErr, mNeed, mRdy, mPend, mWw;
  logic [7:0] mDin, mDout;
  bit         wrQ[$];
  bit         rdQ[$];

  always @(posedge clk) begin : model
    bit commit;
    bit hit;
    bit clr;
    bit anyEv;
    logic [1:0] s;
    if (!rstN) begin
      mCtrl = 3'b000; mErr = 0; mNeed = 0; mRdy = 0; mPend = 0; mWw = 0;
      mDin = 8'h00; mDout = 8'h00;
      wrQ = '{0, 0, 0};
      rdQ = '{0, 0};
    end else begin
      commit = wrQ[1] && !wrQ[2];
      hit    = busPsenN && (busAddr[7:2] == BASE);
      s      = busAddr[1:0];
      clr    = commit && hit && (s == 2'd1);
      anyEv  = appError || appNeedData || appOutValid;
      mPend  = (mPend && !(clr && !busDataIn[3])) || (mCtrl[1] && anyEv);
      mErr   = (mErr  && !(clr && !busDataIn[7])) || appError;
      mNeed  = (mNeed && !(clr && !busDataIn[6])) || appNeedData;
      mRdy   = (mRdy  && !(clr && !busDataIn[5])) || appOutValid;
      if (appOutValid) mDout = appWordOut;
      mWw = commit && hit && (s == 2'd2);
      if (mWw) mDin = busDataIn;
      if (commit && hit && s == 2'd0) mCtrl = busDataIn[7:5];
      wrQ.push_front(!busWrN); void'(wrQ.pop_back());
      rdQ.push_front(!busRdN); void'(rdQ.pop_back());
    end
  end

  function automatic logic [7:0] modelRead(input logic [1:0] s);
    case (s)
      2'd0:    return {mCtrl, 5'b0};
      2'd1:    return {mErr, mNeed, mRdy, appBusy, mPend, 3'b0};
      2'd2:    return mDin;
      default: return mDout;
    endcase
  endfunction

  always @(posedge clk) begin : compare
    logic [7:0] expRd;
    logic [11:0] expV, actV;
    #5;
    expRd = (rstN && rdQ[1] && busPsenN && busAddr[7:2] == BASE) ? modelRead(busAddr[1:0]) : 8'h00;
    expV = {!mPend, mCtrl[2], mCtrl[0], mWw, expRd};
    actV = {intN, appRstN, appStart, appWordWr, rdData};
    checks++;
    if (actV !== expV) begin
      errors++;
      $display("FAIL R11/R8/R4/R9 model compare at %0t: actual=%h expected=%h", $time, actV, expV);
    end
    if (appWord !== mDin) begin
      errors++;
      $display("FAIL R9 model appWord at %0t: actual=%h expected=%h", $time, appWord, mDin);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic checkEq(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busWrite(input logic [5:0] base, input logic [1:0] sel, input logic [7:0] d,
                          input bit psenLow = 0, input bit needAtCommit = 0);
    @(negedge clk);
    busAddr = {base, sel}; busDataIn = d; busPsenN = !psenLow; busWrN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    if (needAtCommit) appNeedData = 1'b1;
    @(negedge clk);
    appNeedData = 1'b0;
    busWrN = 1'b1;
    idle(3);
    busPsenN = 1'b1;
  endtask

  task automatic busRead(input logic [5:0] base, input logic [1:0] sel, output logic [7:0] v,
                         input bit psenLow = 0);
    @(negedge clk);
    busAddr = {base, sel}; busPsenN = !psenLow; busRdN = 1'b0;
    @(posedge clk);
    @(posedge clk);
    #5 v = rdData;
    @(negedge clk);
    busRdN = 1'b1;
    idle(3);
    busPsenN = 1'b1;
  endtask

  task automatic pulseOut(input logic [7:0] w);
    @(negedge clk);
    appWordOut = w; appOutValid = 1'b1;
    @(negedge clk);
    appOutValid = 1'b0;
    idle(1);
  endtask

  task automatic pulseNeed();
    @(negedge clk);
    appNeedData = 1'b1;
    @(negedge clk);
    appNeedData = 1'b0;
    idle(1);
  endtask

  // ---------------- scenario ----------------
  initial begin : main
    logic [7:0] v;
    idle(4);
    checkEq("R12 reset intN", {7'b0, intN}, 8'h01);
    checkEq("R12 reset appRstN", {7'b0, appRstN}, 8'h00);
    checkEq("R12 reset rdData", rdData, 8'h00);
    rstN = 1'b1;
    idle(2);
    busRead(BASE, 2'd0, v);
    checkEq("R12 control after reset", v, 8'h00);

    busWrite(BASE, 2'd0, 8'hFF);
    busRead(BASE, 2'd0, v);
    checkEq("R3 control layout, reserved bits zero", v, 8'hE0);
    checkEq("R3 appStart", {7'b0, appStart}, 8'h01);
    checkEq("R4 appRstN released", {7'b0, appRstN}, 8'h01);

    busWrite(BASE, 2'd0, 8'h00, 1);
    busRead(BASE, 2'd0, v);
    checkEq("R2 fetch-cycle write ignored", v, 8'hE0);
    busRead(BASE, 2'd0, v, 1);
    checkEq("R2 fetch-cycle read returns zero", v, 8'h00);

    busWrite(OTHER, 2'd0, 8'h00);
    busRead(BASE, 2'd0, v);
    checkEq("R1 foreign base write ignored", v, 8'hE0);
    busRead(OTHER, 2'd0, v);
    checkEq("R1 foreign base read zero", v, 8'h00);

    busWrite(BASE, 2'd2, 8'h5A);
    checkEq("R9 appWord", appWord, 8'h5A);
    busRead(BASE, 2'd2, v);
    checkEq("R9 input word readback", v, 8'h5A);

    pulseOut(8'hC3);
    checkEq("R8 intN after ready", {7'b0, intN}, 8'h00);
    busRead(BASE, 2'd3, v);
    checkEq("R10 output word", v, 8'hC3);
    busRead(BASE, 2'd1, v);
    checkEq("R5 status ready+pending", v, 8'h28);
    busWrite(BASE, 2'd3, 8'h11);
    busRead(BASE, 2'd3, v);
    checkEq("R10 output word write ignored", v, 8'hC3);

    busWrite(BASE, 2'd1, 8'hFF);
    busRead(BASE, 2'd1, v);
    checkEq("R6 write ones keeps flags", v, 8'h28);
    busWrite(BASE, 2'd1, 8'h00);
    busRead(BASE, 2'd1, v);
    checkEq("R6 write zero clears", v, 8'h00);
    checkEq("R6 intN released", {7'b0, intN}, 8'h01);

    appBusy = 1'b1;
    busRead(BASE, 2'd1, v);
    checkEq("R5 busy bit live", v, 8'h10);
    appBusy = 1'b0;

    @(negedge clk); appError = 1'b1;
    busWrite(BASE, 2'd1, 8'h00);
    busRead(BASE, 2'd1, v);
    checkEq("R6 persistent error stays", v, 8'h88);
    @(negedge clk); appError = 1'b0;
    busWrite(BASE, 2'd1, 8'h00);
    busRead(BASE, 2'd1, v);
    checkEq("R6 error cleared after cause gone", v, 8'h00);

    pulseNeed();
    busRead(BASE, 2'd1, v);
    checkEq("R5 need flag", v, 8'h48);
    busWrite(BASE, 2'd1, 8'h00, 0, 1);
    busRead(BASE, 2'd1, v);
    checkEq("R7 set wins over clear", v, 8'h48);
    busWrite(BASE, 2'd1, 8'h00);

    busWrite(BASE, 2'd0, 8'hA0);
    pulseOut(8'h3C);
    checkEq("R8 masked intN stays high", {7'b0, intN}, 8'h01);
    busRead(BASE, 2'd1, v);
    checkEq("R8 flag set without pending", v, 8'h20);
    busWrite(BASE, 2'd1, 8'h00);

    busWrite(BASE, 2'd0, 8'h00);
    checkEq("R4 appRstN held", {7'b0, appRstN}, 8'h00);
    checkEq("R3 appStart cleared", {7'b0, appStart}, 8'h00);

    idle(4);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : watchdog
    #(20 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule